// File: doc/BRIEF.md
# Timer/Counter with Shared Watchdog Prescaler

This block holds an 8-bit timer/counter and a watchdog counter that share one programmable power-of-two prescaler. An 8-bit mode register decides what the timer counts (instruction-cycle enables or edges on an external pin), which polarity of pin edge counts, and which of the two counters owns the prescaler. The counter that does not own the prescaler advances directly on its own events.

The timer reports each wrap from 0xFF to 0x00 with a one-cycle overflow pulse, which the surrounding interrupt logic turns into its timer flag. The watchdog advances on a plain base-tick input. Unless software clears it in time with the clear command or the sleep command, it issues a one-cycle time-out reset request. A configuration input can switch the watchdog off for good. The division ratio a prescale code selects is one step lower when the watchdog owns the prescaler than when the timer owns it.

Top module: `tmr_wdt_top`

## Requirements
- R1: Reset loads the mode register with 0xFF and the timer with 0x00, and holds both pulse outputs low.
- R2: A write with wr_sel_i=1 loads the mode register. Its fields are: bits [2:0] the prescale code, bit 3 the owner (1 = watchdog, 0 = timer), bit 4 the edge select (1 = falling), bit 5 the source select (1 = external pin). Bits [7:6] are stored and read back on mode_o.
- R3: With the internal source selected and the watchdog owning the prescaler, the timer advances by one for each clock cycle in which cyc_en_i is high.
- R4: When the timer owns the prescaler, the timer advances once per 2^(code+1) source events, which gives ratios from 1:2 up to 1:256.
- R5: With the pin source selected, the pin passes through two synchronizer flops. Only the selected polarity of transition counts, and cyc_en_i has no effect.
- R6: An advance from 0xFF to 0x00 produces a one-cycle pulse on tmr_ovf_o.
- R7: A write with wr_sel_i=0 loads the timer. It takes priority over an advance in the same cycle, and it clears the prescaler when the timer owns it.
- R8: The watchdog counts 2^WDT_W events and pulses wdt_rst_o on the event that wraps it. An event is one wdt_tick_i when the timer owns the prescaler, and one prescaler output at a ratio of 1:2^code when the watchdog owns it.
- R9: wdt_clr_i or sleep_i sets the watchdog count to zero, and also the prescaler when the watchdog owns it.
- R10: While wdt_dis_i is high, the watchdog count stays at zero and wdt_rst_o never pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cyc_en_i | input | 1 | Instruction-cycle enable, the internal count source |
| ext_pin_i | input | 1 | External count pin, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 = timer, 1 = mode register |
| wr_data_i | input | 8 | Write data |
| wdt_clr_i | input | 1 | Clear-watchdog command strobe |
| sleep_i | input | 1 | Sleep command strobe, also clears the watchdog |
| wdt_tick_i | input | 1 | Watchdog base tick |
| wdt_dis_i | input | 1 | Static watchdog disable |
| tmr_cnt_o | output | 8 | Timer value |
| mode_o | output | 8 | Mode register value |
| tmr_ovf_o | output | 1 | Timer overflow pulse |
| wdt_rst_o | output | 1 | Watchdog time-out reset request |

## Verification
A prescaler left holding a stale count shows up as a timer advance or a watchdog time-out that arrives too early. The error is off by exactly the stale residue, so it becomes visible within one division period. The bench therefore clears the prescaler, feeds a partial count, clears it again and then counts up to one event short of the threshold. A misrouted owner bit or an off-by-one ratio changes the timer value after a known number of enables, or moves the time-out by a factor of two. Each of these is seen as soon as the stimulus batch finishes.

// File: rtl/tmr_wdt_pkg.sv
package tmr_wdt_pkg;
  localparam int DATA_W = 8;

  // bit positions are decoded by the write path: [2:0] code, 3 owner, 4 edge, 5 source
  typedef struct packed {
    logic [1:0] spare;
    logic       src_pin;
    logic       fall_edge;
    logic       wdt_own;
    logic [2:0] ps;
  } mode_t;

  localparam mode_t MODE_RST = '1;
endpackage

// File: rtl/tmr_pin_edge.sv
module tmr_pin_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic fall_i,
  output logic ev_o
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign ev_o = fall_i ? (~s2_q & prev_q) : (s2_q & ~prev_q);

  // one polarity only, so never two events in a row
  a_r5_no_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_o && $stable(fall_i)) |=> !ev_o);
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PS_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            clr_i,
  input  logic [PS_W-1:0] ps_i,
  input  logic            wdt_own_i,
  output logic            out_o
);
  localparam int CNT_W = 1 << PS_W;

  logic [CNT_W-1:0] cnt_q, limit;
  logic [PS_W:0]    shamt;

  // watchdog owner divides one step less than timer owner
  assign shamt = wdt_own_i ? {1'b0, ps_i} : {1'b0, ps_i} + 1'b1;
  assign limit = ~({CNT_W{1'b1}} << shamt);
  assign out_o = tick_i && !clr_i && (cnt_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= out_o ? '0 : cnt_q + 1'b1;
  end

  a_r9_pre_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !out_o || (limit == '0));
endmodule

// File: rtl/tmr_watchdog.sv
module tmr_watchdog #(
  parameter int WDT_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ev_i,
  input  logic clr_i,
  input  logic dis_i,
  output logic rst_o
);
  logic [WDT_W-1:0] cnt_q;
  logic             rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rst_q <= 1'b0;
    end else if (dis_i || clr_i) begin
      cnt_q <= '0;
      rst_q <= 1'b0;
    end else begin
      if (ev_i) cnt_q <= cnt_q + 1'b1;
      rst_q <= ev_i && (&cnt_q);
    end
  end

  assign rst_o = rst_q;

  a_r9_clear_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !rst_o);
  a_r10_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_i |=> !rst_o);
endmodule

// File: rtl/tmr_wdt_top.sv
module tmr_wdt_top
  import tmr_wdt_pkg::*;
#(
  parameter int WDT_W = 8,
  parameter int PS_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_en_i,
  input  logic              ext_pin_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wdt_clr_i,
  input  logic              sleep_i,
  input  logic              wdt_tick_i,
  input  logic              wdt_dis_i,
  output logic [DATA_W-1:0] tmr_cnt_o,
  output logic [DATA_W-1:0] mode_o,
  output logic              tmr_ovf_o,
  output logic              wdt_rst_o
);
  mode_t             mode_q;
  logic [DATA_W-1:0] tmr_q;
  logic              ovf_q;
  logic              pin_ev, src_ev, pre_tick, pre_out, pre_clr;
  logic              tmr_ev, wdt_ev, tmr_wr, mode_wr, wdt_clr;

  assign tmr_wr  = wr_en_i & ~wr_sel_i;
  assign mode_wr = wr_en_i &  wr_sel_i;
  assign wdt_clr = wdt_clr_i | sleep_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mode_q <= MODE_RST;
    else if (mode_wr) mode_q <= mode_t'(wr_data_i);
  end

  tmr_pin_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (ext_pin_i),
    .fall_i (mode_q.fall_edge),
    .ev_o   (pin_ev)
  );

  assign src_ev   = mode_q.src_pin ? pin_ev : cyc_en_i;
  assign pre_tick = mode_q.wdt_own ? wdt_tick_i : src_ev;
  assign pre_clr  = mode_q.wdt_own ? wdt_clr : tmr_wr;
  assign tmr_ev   = mode_q.wdt_own ? src_ev : pre_out;
  assign wdt_ev   = mode_q.wdt_own ? pre_out : wdt_tick_i;

  tmr_prescaler #(.PS_W(PS_W)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (pre_tick),
    .clr_i     (pre_clr),
    .ps_i      (mode_q.ps),
    .wdt_own_i (mode_q.wdt_own),
    .out_o     (pre_out)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q <= '0;
      ovf_q <= 1'b0;
    end else if (tmr_wr) begin
      tmr_q <= wr_data_i;
      ovf_q <= 1'b0;
    end else begin
      if (tmr_ev) tmr_q <= tmr_q + 1'b1;
      ovf_q <= tmr_ev && (&tmr_q);
    end
  end

  tmr_watchdog #(.WDT_W(WDT_W)) u_wdt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ev_i   (wdt_ev),
    .clr_i  (wdt_clr),
    .dis_i  (wdt_dis_i),
    .rst_o  (wdt_rst_o)
  );

  assign tmr_cnt_o = tmr_q;
  assign mode_o    = mode_q;
  assign tmr_ovf_o = ovf_q;

  a_r6_ovf_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_ovf_o |-> tmr_cnt_o == '0);
  a_r3_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tmr_wr |=> (tmr_cnt_o == $past(tmr_cnt_o)) || (tmr_cnt_o == $past(tmr_cnt_o) + 8'd1));
  a_r7_write_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_wr |=> tmr_cnt_o == $past(wr_data_i));
  a_r2_mode_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr |=> mode_o == $past(wr_data_i));
endmodule

// File: tb/tmr_wdt_top_tb_top.sv
module tmr_wdt_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_en = 1'b0, ext_pin = 1'b0, wr_en = 1'b0, wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wdt_clr = 1'b0, sleep = 1'b0, wdt_tick = 1'b0, wdt_dis = 1'b0;
  logic [7:0] tmr_cnt, mode;
  logic       tmr_ovf, wdt_rst;

  int errors = 0, checks = 0, ovf_n = 0, rst_n_cnt = 0;
  bit done = 1'b0;

  typedef struct {
    string req;
    int    sel;
    int    exp;
  } item_t;
  item_t sb_q[$];

  always #5 clk = ~clk;

  tmr_wdt_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cyc_en_i(cyc_en), .ext_pin_i(ext_pin),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .wdt_clr_i(wdt_clr), .sleep_i(sleep), .wdt_tick_i(wdt_tick), .wdt_dis_i(wdt_dis),
    .tmr_cnt_o(tmr_cnt), .mode_o(mode), .tmr_ovf_o(tmr_ovf), .wdt_rst_o(wdt_rst)
  );

  always @(negedge clk) begin
    if (tmr_ovf) ovf_n++;
    if (wdt_rst) rst_n_cnt++;
  end

  // monitor: compares queued expectations against settled outputs
  always @(negedge clk) begin
    #2;
    while (sb_q.size() > 0) begin
      item_t it;
      int act;
      it = sb_q.pop_front();
      case (it.sel)
        0:       act = int'(tmr_cnt);
        1:       act = int'(mode);
        2:       act = ovf_n;
        default: act = rst_n_cnt;
      endcase
      checks++;
      if (act != it.exp) begin
        errors++;
        $display("FAIL %s: actual=%0d expected=%0d", it.req, act, it.exp);
      end
    end
  end

  task automatic expect_item(string req, int sel, int exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    sb_q.push_back(it);
  endtask

  task automatic write_reg(logic sel, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic hold_cyc(int n);
    @(negedge clk); cyc_en = 1'b1;
    repeat (n) @(negedge clk);
    cyc_en = 1'b0;
  endtask

  task automatic hold_tick(int n);
    @(negedge clk); wdt_tick = 1'b1;
    repeat (n) @(negedge clk);
    wdt_tick = 1'b0;
  endtask

  task automatic pulse_clr(logic use_sleep);
    @(negedge clk);
    if (use_sleep) sleep = 1'b1; else wdt_clr = 1'b1;
    @(negedge clk); sleep = 1'b0; wdt_clr = 1'b0;
  endtask

  task automatic pin_pairs(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_pin = 1'b1;
      repeat (4) @(negedge clk);
      ext_pin = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    expect_item("R1 mode reset", 1, 255);
    expect_item("R1 timer reset", 0, 0);
    expect_item("R1 no ovf", 2, 0);
    expect_item("R1 no wdt rst", 3, 0);

    // R2 + R3: internal source, watchdog owns prescaler
    write_reg(1'b1, 8'hC8);
    settle();
    expect_item("R2 mode readback", 1, 8'hC8);
    hold_cyc(10); settle();
    expect_item("R3 internal count", 0, 10);

    // R4: timer owns prescaler
    write_reg(1'b1, 8'h02); write_reg(1'b0, 8'h00);
    hold_cyc(40); settle();
    expect_item("R4 ratio 1:8", 0, 5);
    write_reg(1'b1, 8'h00); write_reg(1'b0, 8'h00);
    hold_cyc(10); settle();
    expect_item("R4 ratio 1:2", 0, 5);
    write_reg(1'b1, 8'h07); write_reg(1'b0, 8'h00);
    hold_cyc(512); settle();
    expect_item("R4 ratio 1:256", 0, 2);

    // R5: pin source
    write_reg(1'b1, 8'h28); write_reg(1'b0, 8'h00);
    pin_pairs(3); settle();
    expect_item("R5 rising edges", 0, 3);
    hold_cyc(5); settle();
    expect_item("R5 cyc_en ignored", 0, 3);
    write_reg(1'b1, 8'h38); write_reg(1'b0, 8'h00);
    pin_pairs(2); settle();
    expect_item("R5 falling edges", 0, 2);

    // R6: overflow
    write_reg(1'b1, 8'h08); write_reg(1'b0, 8'hFE);
    hold_cyc(2); settle();
    expect_item("R6 wrap value", 0, 0);
    expect_item("R6 ovf pulse", 2, 1);

    // R7: write clears timer-owned prescaler
    write_reg(1'b1, 8'h02); write_reg(1'b0, 8'h00);
    hold_cyc(5); write_reg(1'b0, 8'h00);
    hold_cyc(5); settle();
    expect_item("R7 residue dropped", 0, 0);
    hold_cyc(3); settle();
    expect_item("R7 full period", 0, 1);

    // R8: watchdog direct when timer owns prescaler
    write_reg(1'b1, 8'h00); pulse_clr(1'b0);
    hold_tick(255); settle();
    expect_item("R8 direct 255 ticks", 3, 0);
    hold_tick(1); settle();
    expect_item("R8 direct timeout", 3, 1);
    // watchdog owns prescaler, code 1 -> 1:2
    write_reg(1'b1, 8'h09); pulse_clr(1'b0);
    hold_tick(511); settle();
    expect_item("R8 1:2 before timeout", 3, 1);
    hold_tick(1); settle();
    expect_item("R8 1:2 timeout", 3, 2);
    // code 0 -> 1:1
    write_reg(1'b1, 8'h08); pulse_clr(1'b0);
    hold_tick(256); settle();
    expect_item("R8 1:1 timeout", 3, 3);

    // R9: clear and sleep hold off time-out; clear resets prescaler
    pulse_clr(1'b0);
    hold_tick(200); pulse_clr(1'b0); hold_tick(200); pulse_clr(1'b1);
    hold_tick(200); settle();
    expect_item("R9 clear and sleep", 3, 3);
    write_reg(1'b1, 8'h09); pulse_clr(1'b0);
    hold_tick(1); pulse_clr(1'b0);
    hold_tick(511); settle();
    expect_item("R9 prescaler cleared", 3, 3);
    hold_tick(1); settle();
    expect_item("R9 timeout after clear", 3, 4);

    // R10: disabled
    wdt_dis = 1'b1; write_reg(1'b1, 8'h00);
    hold_tick(600); settle();
    expect_item("R10 disabled", 3, 4);
    wdt_dis = 1'b0;
    hold_tick(255); settle();
    expect_item("R10 count held at zero", 3, 4);

    // R1 again: reset restores mode
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    settle();
    expect_item("R1 mode after re-reset", 1, 255);
    expect_item("R1 timer after re-reset", 0, 0);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule